// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache Controller

This block is a read/write cache placed between a processor request port and a slower word-wide main-memory port. Each 24-bit byte address selects a 4-byte block; the block number modulo the number of sets selects a set of two lines, and a stored tag in each line tells which block that line currently holds. Hits are served from the local arrays, with no memory traffic. Writes update only the cache and mark the line modified.

On a miss the controller picks a victim line in the addressed set. An empty line is taken first. Otherwise it takes the line that was not touched most recently. If the victim holds modified data, that word is first copied back to its own memory address. The missing block is then fetched, and the request completes from the freshly filled line. A write miss allocates the block and merges the processor's enabled bytes into it.

The set-field width is a parameter; the tag takes the remaining upper bits. The full-size arrangement uses a 13-bit set field and a 9-bit tag. The default elaborates a smaller 6-bit set field.

Top module: `cache2w_top`

## Requirements
- R1: Address bits [1:0] select a byte within the 4-byte block. The next SET_W bits select the set, and the remaining upper bits form the tag. Every memory-port address is word aligned, with bits [1:0] equal to 0, and equals {tag, set, 00} of the block concerned.
- R2: A read whose block is present returns the stored word with `rsp_valid` high in the second cycle after the accepting edge, and it raises no memory request.
- R3: A write whose block is present replaces byte i (bits 8i+7..8i) only where `req_be[i]` is 1, makes no memory request, and marks the line modified. The response word is the updated line content.
- R4: A read miss issues exactly one memory read, for the block's word-aligned address, and returns the word the memory supplied.
- R5: A write miss fetches the block, merges the enabled bytes into it, marks the line modified, and returns the merged word. A later eviction of that line writes the merged word back to memory.
- R6: On a miss, an empty line is filled before any valid line is evicted, with line 0 before line 1. When both lines are valid, the line not accessed most recently in that set is replaced. Any hit or fill makes its line the most recently accessed one.
- R7: A victim marked modified is written to memory at its own block address, with its current data, before the refill read. A clean victim causes no memory write.
- R8: `req_ready` is high only while the controller is idle. In particular, it is low for every cycle in which `mem_req` is high.
- R9: Reset empties every line, so the first access to any block after reset is a miss.
- R10: `mem_req`, `mem_we` and `mem_addr` remain stable until `mem_ack`. The acknowledge may come any number of cycles later, and read data is taken in the cycle of `mem_ack`.
- R11: Each accepted request produces exactly one single-cycle `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read word, or updated word for writes |
| mem_req | output | 1 | Memory request held until acknowledge |
| mem_we | output | 1 | 1 = memory write (copy-back), 0 = memory read |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | 32 | Copy-back data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory transfer complete |

## Verification
The bench shrinks the cache to four sets and limits traffic to four tags, giving sixteen blocks in all. It sweeps every block with writes that use all sixteen byte-enable patterns, then reads every block back. A directed sequence on one set separates the empty-line-first rule from the least-recent rule, and a clean eviction from a modified one. A long pseudo-random mix of reads, writes, tags, sets, byte offsets and memory acknowledge delays follows. Every operation is checked against a bench model of line contents and recency, which tells hits apart from misses through the latency and memory traffic, and clean evictions from modified ones through the copy-back address and data.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned BE_W   = WORD_W / 8;
  localparam int unsigned OFF_W  = 2;
  localparam int unsigned WAYS   = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WRITEBACK,
    ST_REFILL,
    ST_RESPOND
  } cstate_e;

  // Byte-wise merge of new data into an existing word.
  function automatic logic [WORD_W-1:0] merge_word(
    input logic [WORD_W-1:0] base,
    input logic [WORD_W-1:0] upd,
    input logic [BE_W-1:0]   be
  );
    logic [WORD_W-1:0] r;
    r = base;
    for (int b = 0; b < BE_W; b++) begin
      if (be[b]) r[8*b +: 8] = upd[8*b +: 8];
    end
    return r;
  endfunction

  // Victim choice: empty line 0, then empty line 1, else the line not used last.
  function automatic logic pick_victim(
    input logic [WAYS-1:0] valid,
    input logic            mru
  );
    if (!valid[0])      return 1'b0;
    else if (!valid[1]) return 1'b1;
    else                return ~mru;
  endfunction

endpackage

// File: rtl/cache2w_tagstore.sv
module cache2w_tagstore
  import cache2w_pkg::*;
#(
  parameter int unsigned SET_W = 6,
  parameter int unsigned TAG_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SET_W-1:0]           rd_set,
  output logic [WAYS-1:0]            rd_valid,
  output logic [WAYS-1:0]            rd_dirty,
  output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
  output logic                       rd_mru,
  input  logic                       upd_en,
  input  logic [SET_W-1:0]           upd_set,
  input  logic                       upd_way,
  input  logic [TAG_W-1:0]           upd_tag,
  input  logic                       upd_dirty
);
  localparam int unsigned NSETS = 1 << SET_W;

  logic [NSETS-1:0] mru_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [NSETS-1:0] valid_q;
    logic             dirty_q [NSETS];
    logic [TAG_W-1:0] tag_q   [NSETS];
    logic             sel;

    assign sel = upd_en && (upd_way == 1'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= '0;
      end else if (sel) begin
        valid_q[upd_set] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        dirty_q[upd_set] <= upd_dirty;
        tag_q[upd_set]   <= upd_tag;
      end
    end

    assign rd_valid[w] = valid_q[rd_set];
    assign rd_dirty[w] = dirty_q[rd_set] && valid_q[rd_set];
    assign rd_tag[w]   = tag_q[rd_set];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mru_q <= '0;
    end else if (upd_en) begin
      mru_q[upd_set] <= upd_way;
    end
  end

  assign rd_mru = mru_q[rd_set];

endmodule

// File: rtl/cache2w_datastore.sv
module cache2w_datastore
  import cache2w_pkg::*;
#(
  parameter int unsigned SET_W = 6
) (
  input  logic                        clk,
  input  logic [SET_W-1:0]            rd_set,
  output logic [WAYS-1:0][WORD_W-1:0] rd_data,
  input  logic                        wr_en,
  input  logic                        wr_way,
  input  logic [SET_W-1:0]            wr_set,
  input  logic [WORD_W-1:0]           wr_data
);
  localparam int unsigned NSETS = 1 << SET_W;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [WORD_W-1:0] word_q [NSETS];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == 1'(w))) begin
        word_q[wr_set] <= wr_data;
      end
    end

    assign rd_data[w] = word_q[rd_set];
  end

endmodule

// File: rtl/cache2w_match.sv
module cache2w_match
  import cache2w_pkg::*;
#(
  parameter int unsigned TAG_W = 16
) (
  input  logic [WAYS-1:0]            line_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] line_tag,
  input  logic                       set_mru,
  input  logic [TAG_W-1:0]           req_tag,
  output logic                       hit,
  output logic                       hit_way,
  output logic                       victim_way
);
  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = line_valid[w] && (line_tag[w] == req_tag);
  end

  assign hit        = |hit_vec;
  assign hit_way    = hit_vec[1];
  assign victim_way = pick_victim(line_valid, set_mru);

endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
  import cache2w_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned SET_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack
);
  localparam int unsigned TAG_W = ADDR_W - SET_W - OFF_W;
  localparam int unsigned BLK_W = ADDR_W - OFF_W;

  cstate_e            state_q, state_d;
  logic [BLK_W-1:0]   blk_q;
  logic               we_q;
  logic [WORD_W-1:0]  wdata_q;
  logic [BE_W-1:0]    be_q;
  logic               victim_q;
  logic [WORD_W-1:0]  rdata_q;

  logic [SET_W-1:0]   cur_set;
  logic [TAG_W-1:0]   cur_tag;

  logic [WAYS-1:0]              t_valid, t_dirty;
  logic [WAYS-1:0][TAG_W-1:0]   t_tag;
  logic                         t_mru;
  logic [WAYS-1:0][WORD_W-1:0]  d_word;

  logic hit, hit_way, victim_way;

  // Named internal events, also observed by the checker.
  logic lookup_hit, lookup_miss, evict_dirty, refill_done, wb_done;
  logic [WORD_W-1:0] src_word, line_word;
  logic unused_off;

  assign unused_off = ^req_addr[OFF_W-1:0];

  assign cur_set = blk_q[SET_W-1:0];
  assign cur_tag = blk_q[BLK_W-1 -: TAG_W];

  cache2w_tagstore #(.SET_W(SET_W), .TAG_W(TAG_W)) tags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_set    (cur_set),
    .rd_valid  (t_valid),
    .rd_dirty  (t_dirty),
    .rd_tag    (t_tag),
    .rd_mru    (t_mru),
    .upd_en    (lookup_hit || refill_done),
    .upd_set   (cur_set),
    .upd_way   (lookup_hit ? hit_way : victim_q),
    .upd_tag   (cur_tag),
    .upd_dirty (lookup_hit ? (t_dirty[hit_way] || we_q) : we_q)
  );

  cache2w_datastore #(.SET_W(SET_W)) data_i (
    .clk     (clk),
    .rd_set  (cur_set),
    .rd_data (d_word),
    .wr_en   ((lookup_hit && we_q) || refill_done),
    .wr_way  (lookup_hit ? hit_way : victim_q),
    .wr_set  (cur_set),
    .wr_data (line_word)
  );

  cache2w_match #(.TAG_W(TAG_W)) match_i (
    .line_valid (t_valid),
    .line_tag   (t_tag),
    .set_mru    (t_mru),
    .req_tag    (cur_tag),
    .hit        (hit),
    .hit_way    (hit_way),
    .victim_way (victim_way)
  );

  assign lookup_hit  = (state_q == ST_LOOKUP) && hit;
  assign lookup_miss = (state_q == ST_LOOKUP) && !hit;
  assign evict_dirty = lookup_miss && t_valid[victim_way] && t_dirty[victim_way];
  assign refill_done = (state_q == ST_REFILL) && mem_ack;
  assign wb_done     = (state_q == ST_WRITEBACK) && mem_ack;

  assign src_word  = (state_q == ST_REFILL) ? mem_rdata : d_word[hit_way];
  assign line_word = we_q ? merge_word(src_word, wdata_q, be_q) : src_word;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (req_valid) state_d = ST_LOOKUP;
      ST_LOOKUP:    if (hit)              state_d = ST_RESPOND;
                    else if (evict_dirty) state_d = ST_WRITEBACK;
                    else                  state_d = ST_REFILL;
      ST_WRITEBACK: if (mem_ack) state_d = ST_REFILL;
      ST_REFILL:    if (mem_ack) state_d = ST_RESPOND;
      ST_RESPOND:   state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      blk_q    <= '0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
      be_q     <= '0;
      victim_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid) begin
        blk_q   <= req_addr[ADDR_W-1:OFF_W];
        we_q    <= req_write;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
      if (lookup_miss) victim_q <= victim_way;
      if (lookup_hit || refill_done) rdata_q <= line_word;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESPOND);
  assign rsp_rdata = rdata_q;

  assign mem_req   = (state_q == ST_WRITEBACK) || (state_q == ST_REFILL);
  assign mem_we    = (state_q == ST_WRITEBACK);
  assign mem_addr  = (state_q == ST_WRITEBACK)
                   ? {t_tag[victim_q], cur_set, {OFF_W{1'b0}}}
                   : {cur_tag, cur_set, {OFF_W{1'b0}}};
  assign mem_wdata = d_word[victim_q];

endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              lookup_hit,
  input logic              evict_dirty,
  input logic              wb_done
);

  AST_MEM_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R1

  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |=> !mem_req); // R2

  AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !$past(mem_req)) |-> $past(evict_dirty)); // R7

  AST_WB_THEN_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |=> (mem_req && !mem_we)); // R7

  AST_READY_LOW_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R8

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R10

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11

endmodule

bind cache2w_top cache2w_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_ack     (mem_ack),
  .mem_addr    (mem_addr),
  .lookup_hit  (lookup_hit),
  .evict_dirty (evict_dirty),
  .wb_done     (wb_done)
);

// File: tb/cache2w_top_tb_top.sv
module cache2w_top_tb_top;

  localparam int unsigned ADDR_W = 24;
  localparam int unsigned SET_W  = 2;
  localparam int unsigned NSET   = 4;
  localparam int unsigned NTAG   = 4;
  localparam int unsigned NBLK   = NSET * NTAG;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic [3:0]        req_be = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_wdata;
  logic [31:0]       mem_rdata = '0;
  logic              mem_ack = 1'b0;

  always #2.5 clk = ~clk;

  cache2w_top #(.ADDR_W(ADDR_W), .SET_W(SET_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  // Backing memory and processor-visible image.
  logic [31:0] bmem [NBLK];
  logic [31:0] ref_mem [NBLK];
  int mem_rd_n = 0, mem_wr_n = 0;
  int last_rd_idx = -1, last_wr_idx = -1;
  int ack_dly = 0;
  int ready_viol = 0;

  // Bench model of line state.
  bit m_valid [NSET][2];
  bit m_dirty [NSET][2];
  int m_tag   [NSET][2];
  int m_mru   [NSET];

  function automatic int blk_index(input logic [ADDR_W-1:0] a);
    int t, s;
    t = int'(a[ADDR_W-1:4]);
    s = int'(a[3:2]);
    if (t >= NTAG) return -1;
    return t * NSET + s;
  endfunction

  function automatic logic [31:0] byte_mix(input logic [31:0] o, input logic [31:0] n,
                                            input logic [3:0] be);
    logic [31:0] mask;
    mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    return (n & mask) | (o & ~mask);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  endtask

  // Memory responder with rotating acknowledge delay.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req && !mem_ack) begin
        repeat (ack_dly) @(negedge clk);
        ack_dly = (ack_dly + 1) % 5;
        if (mem_we) begin
          last_wr_idx = blk_index(mem_addr);
          if (last_wr_idx >= 0) bmem[last_wr_idx] = mem_wdata;
          mem_wr_n++;
        end else begin
          last_rd_idx = blk_index(mem_addr);
          mem_rdata = (last_rd_idx >= 0) ? bmem[last_rd_idx] : 32'hDEAD_BEEF;
          mem_rd_n++;
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  // R8 monitor: request port must be closed while memory is busy.
  always @(negedge clk) begin
    if (rst_n && mem_req && req_ready) ready_viol++;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    report();
  end

  task automatic do_op(input bit we, input int tg, input int st, input logic [1:0] off,
                       input logic [31:0] wd, input logic [3:0] be);
    int idx, way, vict, n, rd0, wr0, wb_idx;
    bit hit, exp_wb;
    logic [31:0] exp_word, got;
    idx = tg * NSET + st;
    hit = 0; way = 0; wb_idx = -1;
    for (int w = 0; w < 2; w++)
      if (m_valid[st][w] && m_tag[st][w] == tg) begin hit = 1; way = w; end
    if (!m_valid[st][0])      vict = 0;
    else if (!m_valid[st][1]) vict = 1;
    else                      vict = 1 - m_mru[st];
    exp_wb = !hit && m_valid[st][vict] && m_dirty[st][vict];
    if (exp_wb) wb_idx = m_tag[st][vict] * NSET + st;
    exp_word = we ? byte_mix(ref_mem[idx], wd, be) : ref_mem[idx];
    rd0 = mem_rd_n; wr0 = mem_wr_n;

    req_valid = 1'b1; req_write = we; req_be = be; req_wdata = wd;
    req_addr  = {20'(tg), 2'(st), off};
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid) begin @(negedge clk); n++; end
    got = rsp_rdata;
    @(negedge clk);
    check(!rsp_valid, "R11", "response pulse longer than one cycle", 32'(rsp_valid), 0);

    if (we) check(got == exp_word, hit ? "R3" : "R5", "write response word", got, exp_word);
    else    check(got == exp_word, hit ? "R2" : "R4", "read data", got, exp_word);

    if (hit) begin
      check(n == 1, "R2", "hit latency", n, 1);
      check(mem_rd_n == rd0 && mem_wr_n == wr0, "R3", "memory traffic on hit",
            (mem_rd_n - rd0) + (mem_wr_n - wr0), 0);
    end else begin
      check(mem_rd_n - rd0 == 1, "R6", "refill reads on miss", mem_rd_n - rd0, 1);
      check(last_rd_idx == idx, "R1", "refill block address", last_rd_idx, idx);
      check(mem_wr_n - wr0 == (exp_wb ? 1 : 0), "R7", "copy-back count",
            mem_wr_n - wr0, exp_wb ? 1 : 0);
      if (exp_wb) begin
        check(last_wr_idx == wb_idx, "R7", "copy-back address", last_wr_idx, wb_idx);
        check(bmem[wb_idx] == ref_mem[wb_idx], "R5", "copy-back data",
              bmem[wb_idx], ref_mem[wb_idx]);
      end
    end

    if (!hit) begin
      way = vict;
      m_valid[st][way] = 1;
      m_tag[st][way]   = tg;
      m_dirty[st][way] = we;
    end else if (we) begin
      m_dirty[st][way] = 1;
    end
    m_mru[st] = way;
    ref_mem[idx] = exp_word;
  endtask

  initial begin
    logic [31:0] seed;
    for (int i = 0; i < NBLK; i++) begin
      bmem[i]    = (32'h1000_0001 * 32'(i + 1)) ^ 32'hC3C3_0000;
      ref_mem[i] = bmem[i];
    end
    for (int s = 0; s < NSET; s++) begin
      m_mru[s] = 0;
      for (int w = 0; w < 2; w++) begin m_valid[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0; end
    end

    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R9", "ready in reset", 32'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req, "R9", "idle outputs after reset",
          {req_ready, rsp_valid, mem_req}, 3'b100);

    // Directed: set 0 replacement order (R6, R7, R9).
    do_op(0, 0, 0, 2'd0, 0, 0);              // miss, empty line 0
    do_op(0, 0, 0, 2'd3, 0, 0);              // hit
    do_op(0, 1, 0, 2'd1, 0, 0);              // miss, empty line 1, no eviction
    do_op(1, 1, 0, 2'd0, 32'h1122_3344, 4'b0101); // write hit, dirty
    do_op(0, 2, 0, 2'd0, 0, 0);              // evicts clean tag 0
    do_op(0, 0, 0, 2'd2, 0, 0);              // evicts dirty tag 1 with copy-back
    do_op(0, 1, 0, 2'd0, 0, 0);              // re-read merged word from memory

    // Sweep: write every block with every byte-enable pattern, then read back.
    for (int b = 0; b < NBLK; b++)
      do_op(1, b / NSET, b % NSET, 2'(b), 32'hA0B0_C0D0 + 32'(b * 32'h0101_0101), 4'(b));
    for (int b = 0; b < NBLK; b++)
      do_op(0, b / NSET, b % NSET, 2'd0, 0, 0);
    for (int b = NBLK - 1; b >= 0; b--)
      do_op(1, b / NSET, b % NSET, 2'd1, 32'h5A5A_0000 ^ 32'(b), 4'(15 - b));

    // Pseudo-random mix.
    seed = 32'h1357_9BDF;
    for (int k = 0; k < 600; k++) begin
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      do_op(seed[0], int'(seed[3:2]), int'(seed[5:4]), seed[7:6], seed ^ 32'(k), seed[11:8]);
    end

    // Final read of every block.
    for (int b = 0; b < NBLK; b++)
      do_op(0, b / NSET, b % NSET, 2'd0, 0, 0);

    check(ready_viol == 0, "R8", "ready high during memory request", ready_viol, 0);
    report();
  end

endmodule